// File: doc/BRIEF.md
# Ping-Pong Merge Sorter for Non-Binary Check-Node Messages

This block is the front end of a check-node unit in a non-binary LDPC decoder. It receives the variable-to-check messages of one check-node update as a stream, one variable node after another. Each message is a Galois-field element (a P-bit code word, field size 2^P) paired with an LLR reliability value. A last-of-node flag marks the final message of each variable node. Messages are delivered one per cycle through a valid/ready handshake.

Messages whose LLR is zero are never sorted. Their field elements are written into a separate zero-element store in arrival order, and an XOR accumulator forms their field sum. The other messages are merged round by round, one round per variable node, into a running list of the K smallest LLRs. Each list entry is tagged with the index of the node it came from. Two list buffers alternate: each round reads the previous list from one buffer and writes the updated list into the other. Round 0 writes buffer 0 and starts from an empty list.

After the last node has been merged, a one-cycle done pulse is raised. A buffer-select output names the buffer that holds the final list, and the list outputs show that buffer. A downstream path constructor reads the final list, the zero-element store and the sum while they are held.

Top module: `nbldpc_msg_sorter`

## Requirements
- R1: After reset the list count, zero count and zero sum read 0, `done` is low, `inReady` is high and `finalSel` is 0.
- R2: A message accepted with LLR 0 is never put in the sorted list. Its element is written into the zero store at the next free slot (arrival order, slot 0 first, slot i at bits [i*P +: P] of `zeroElem`). Once ZD elements are stored, further zero-LLR elements are not stored, and `zeroCnt` saturates at ZD.
- R3: `zeroSum` is the bitwise XOR of the elements of every zero-LLR message accepted in the current update, including any that were not stored. It restarts from 0 with the first message accepted after reset or after a done pulse.
- R4: Round r (node r, counted from 0) writes buffer r mod 2. Round 0 starts from an empty list. After the last round, `finalSel` equals (DC-1) mod 2.
- R5: The final list holds the min(N, K) nonzero-LLR messages with the smallest LLRs, where N is the number of nonzero-LLR messages in the update. Entries are in ascending LLR order, and entry i sits at bits [i*W +: W] of `outLlr` and [i*P +: P] of `outElem`. `outCnt` gives the number of valid entries.
- R6: Among equal LLRs, the entry that arrived earlier comes first, so an entry already stored is never displaced by a newcomer with the same LLR.
- R7: Each list entry carries, at bits [i*IW +: IW] of `outIdx`, the index (0 to DC-1) of the variable node it came from.
- R8: `done` is high for exactly the one cycle after the last message of node DC-1 is accepted. `inReady` is low in that cycle and high in every other cycle.
- R9: From the done pulse until the next message is accepted, the list outputs, zero store outputs, `zeroSum` and `finalSel` hold their values.
- R10: A node that sends no nonzero-LLR message leaves the list unchanged. Its round copies the previous list into the other buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Message present on the inputs |
| inReady | output | 1 | Block can accept a message |
| inElem | input | P | Field element code word |
| inLlr | input | W | LLR of the message (0 = zero-LLR) |
| inLast | input | 1 | Message is the last one of its variable node |
| done | output | 1 | One-cycle pulse after the last round |
| finalSel | output | 1 | Buffer holding the final list |
| outCnt | output | $clog2(K+1) | Number of valid list entries |
| outElem | output | K*P | List field elements, entry i at [i*P +: P] |
| outLlr | output | K*W | List LLRs, entry i at [i*W +: W] |
| outIdx | output | K*IW | List variable-node indices, entry i at [i*IW +: IW] |
| zeroCnt | output | $clog2(ZD+1) | Number of stored zero-LLR elements |
| zeroElem | output | ZD*P | Zero store, slot i at [i*P +: P] |
| zeroSum | output | P | XOR of all zero-LLR elements of the update |

## Verification
The embedded assertions check the following on every cycle:
- both buffers stay sorted in ascending LLR order and never hold a zero LLR;
- the list and zero counts stay within their bounds;
- the XOR accumulator advances by exactly the accepted zero-LLR element;
- the done pulse lasts one cycle and names the buffer with the right parity;
- the stored results stay stable while no message is accepted.

The whole-update properties can only be shown by the bench's scenarios, which compare against a behavioural model of the update:
- which messages survive truncation to K;
- the order among equal LLRs;
- the node tags;
- zero-store overflow;
- the copy through rounds that have no nonzero message.

// File: rtl/msort_pkg.sv
package msort_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic accept;     // message taken this cycle
    logic fresh;      // first message of a round
    logic roundZero;  // round 0: start from empty list
    logic wrSel;      // buffer written this round
    logic clrZero;    // first message of an update
  } strobe_t;
endpackage

// File: rtl/msort_ctrl.sv
module msort_ctrl
  import msort_pkg::*;
#(
  parameter int DC = 6,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  input  logic          inLast,
  output logic          inReady,
  output strobe_t       stb,
  output logic [IW-1:0] nodeIdx,
  output logic          done,
  output logic          finalSel
);
  localparam logic [IW-1:0] LAST_NODE = IW'(DC - 1);
  localparam logic FINAL_PARITY = 1'((DC - 1) % 2);

  logic [IW-1:0] nodeQ;
  logic freshQ, wrSelQ, startQ, doneQ, finalQ;
  logic accept;

  assign accept  = inValid && !doneQ;
  assign inReady = !doneQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      nodeQ  <= '0;
      freshQ <= 1'b1;
      wrSelQ <= 1'b0;
      startQ <= 1'b1;
      doneQ  <= 1'b0;
      finalQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (accept) begin
        startQ <= 1'b0;
        freshQ <= inLast;
        if (inLast) begin
          if (nodeQ == LAST_NODE) begin
            nodeQ  <= '0;
            wrSelQ <= 1'b0;
            startQ <= 1'b1;
            doneQ  <= 1'b1;
            finalQ <= wrSelQ;
          end else begin
            nodeQ  <= nodeQ + 1'b1;
            wrSelQ <= ~wrSelQ;
          end
        end
      end
    end
  end

  always_comb begin
    stb.accept    = accept;
    stb.fresh     = freshQ;
    stb.roundZero = (nodeQ == '0);
    stb.wrSel     = wrSelQ;
    stb.clrZero   = startQ;
  end

  assign nodeIdx  = nodeQ;
  assign done     = doneQ;
  assign finalSel = finalQ;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    doneQ |=> !doneQ);  // R8
  AST_FINAL_PARITY: assert property (@(posedge clk) disable iff (rst)
    $rose(doneQ) |-> (finalQ == FINAL_PARITY));  // R4
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (doneQ && !inValid) |=> $stable(finalQ));  // R9
endmodule

// File: rtl/msort_dpath.sv
module msort_dpath
  import msort_pkg::*;
#(
  parameter int P  = 4,
  parameter int W  = 5,
  parameter int K  = 4,
  parameter int ZD = 8,
  parameter int IW = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  strobe_t                    stb,
  input  logic [IW-1:0]              nodeIdx,
  input  logic [P-1:0]               inElem,
  input  logic [W-1:0]               inLlr,
  input  logic                       readSel,
  output logic [$clog2(K+1)-1:0]     outCnt,
  output logic [K*P-1:0]             outElem,
  output logic [K*W-1:0]             outLlr,
  output logic [K*IW-1:0]            outIdx,
  output logic [$clog2(ZD+1)-1:0]    zeroCnt,
  output logic [ZD*P-1:0]            zeroElem,
  output logic [P-1:0]               zeroSum
);
  localparam int CW  = $clog2(K + 1);
  localparam int ZCW = $clog2(ZD + 1);

  // two list buffers
  logic [P-1:0]  elemQ [2][K];
  logic [W-1:0]  llrQ  [2][K];
  logic [IW-1:0] idxQ  [2][K];
  logic [CW-1:0] cntQ  [2];

  // zero store
  logic [P-1:0]   zElemQ [ZD];
  logic [ZCW-1:0] zCntQ;
  logic [P-1:0]   zSumQ;

  logic          isZero;
  logic          baseSel;
  logic [CW-1:0] baseCnt, newCnt, pos;
  logic [P-1:0]  baseE [K];
  logic [W-1:0]  baseL [K];
  logic [IW-1:0] baseI [K];
  logic [P-1:0]  newE  [K];
  logic [W-1:0]  newL  [K];
  logic [IW-1:0] newI  [K];

  assign isZero  = (inLlr == '0);
  // first message of a round reads the other buffer; later ones extend the write buffer
  assign baseSel = stb.fresh ? ~stb.wrSel : stb.wrSel;

  always_comb begin
    baseCnt = (stb.fresh && stb.roundZero) ? '0 : cntQ[baseSel];
    for (int i = 0; i < K; i++) begin
      baseE[i] = elemQ[baseSel][i];
      baseL[i] = llrQ[baseSel][i];
      baseI[i] = idxQ[baseSel][i];
    end
    // insertion slot: after every stored entry with LLR <= new LLR
    pos = '0;
    for (int i = 0; i < K; i++) begin
      if ((CW'(i) < baseCnt) && (baseL[i] <= inLlr)) pos = CW'(i + 1);
    end
    for (int i = 0; i < K; i++) begin
      if (isZero || (CW'(i) < pos)) begin
        newE[i] = baseE[i];
        newL[i] = baseL[i];
        newI[i] = baseI[i];
      end else if (CW'(i) == pos) begin
        newE[i] = inElem;
        newL[i] = inLlr;
        newI[i] = nodeIdx;
      end else begin
        newE[i] = baseE[(i == 0) ? 0 : i - 1];
        newL[i] = baseL[(i == 0) ? 0 : i - 1];
        newI[i] = baseI[(i == 0) ? 0 : i - 1];
      end
    end
    if (!isZero && (baseCnt < CW'(K))) newCnt = baseCnt + 1'b1;
    else newCnt = baseCnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < 2; b++) begin
        cntQ[b] <= '0;
        for (int i = 0; i < K; i++) begin
          elemQ[b][i] <= '0;
          llrQ[b][i]  <= '0;
          idxQ[b][i]  <= '0;
        end
      end
    end else if (stb.accept) begin
      cntQ[stb.wrSel] <= newCnt;
      for (int i = 0; i < K; i++) begin
        elemQ[stb.wrSel][i] <= newE[i];
        llrQ[stb.wrSel][i]  <= newL[i];
        idxQ[stb.wrSel][i]  <= newI[i];
      end
    end
  end

  logic [ZCW-1:0] zSlot;
  assign zSlot = stb.clrZero ? '0 : zCntQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      zCntQ <= '0;
      zSumQ <= '0;
      for (int i = 0; i < ZD; i++) zElemQ[i] <= '0;
    end else if (stb.accept) begin
      zSumQ <= (stb.clrZero ? '0 : zSumQ) ^ (isZero ? inElem : '0);
      if (isZero && (zSlot < ZCW'(ZD))) begin
        zElemQ[zSlot] <= inElem;
        zCntQ <= zSlot + 1'b1;
      end else begin
        zCntQ <= zSlot;
      end
    end
  end

  always_comb begin
    outCnt = cntQ[readSel];
    for (int i = 0; i < K; i++) begin
      outElem[i*P +: P]  = elemQ[readSel][i];
      outLlr[i*W +: W]   = llrQ[readSel][i];
      outIdx[i*IW +: IW] = idxQ[readSel][i];
    end
    for (int i = 0; i < ZD; i++) zeroElem[i*P +: P] = zElemQ[i];
  end
  assign zeroCnt = zCntQ;
  assign zeroSum = zSumQ;

  for (genvar b = 0; b < 2; b++) begin : g_bufChk
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
      cntQ[b] <= CW'(K));  // R5
    for (genvar g = 0; g < K; g++) begin : g_entry
      AST_NO_ZERO_LLR: assert property (@(posedge clk) disable iff (rst)
        (CW'(g) < cntQ[b]) |-> (llrQ[b][g] != '0));  // R2
      if (g < K - 1) begin : g_pair
        AST_ASCENDING: assert property (@(posedge clk) disable iff (rst)
          (CW'(g + 1) < cntQ[b]) |-> (llrQ[b][g] <= llrQ[b][g+1]));  // R5
      end
    end
  end

  AST_ZCNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    zCntQ <= ZCW'(ZD));  // R2
  AST_XOR_STEP: assert property (@(posedge clk) disable iff (rst)
    (stb.accept && isZero && !stb.clrZero) |=> (zSumQ == $past(zSumQ ^ inElem)));  // R3
  AST_XOR_RESTART: assert property (@(posedge clk) disable iff (rst)
    (stb.accept && stb.clrZero && !isZero) |=> (zSumQ == '0));  // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !stb.accept |=> ($stable(zSumQ) && $stable(zCntQ) && $stable(cntQ[0]) && $stable(cntQ[1])));  // R9
endmodule

// File: rtl/nbldpc_msg_sorter.sv
module nbldpc_msg_sorter
  import msort_pkg::*;
#(
  parameter int P  = 4,
  parameter int DC = 6,
  parameter int K  = 4,
  parameter int W  = 5,
  parameter int ZD = 8,
  localparam int IW  = (DC > 1) ? $clog2(DC) : 1,
  localparam int CW  = $clog2(K + 1),
  localparam int ZCW = $clog2(ZD + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic [P-1:0]      inElem,
  input  logic [W-1:0]      inLlr,
  input  logic              inLast,
  output logic              done,
  output logic              finalSel,
  output logic [CW-1:0]     outCnt,
  output logic [K*P-1:0]    outElem,
  output logic [K*W-1:0]    outLlr,
  output logic [K*IW-1:0]   outIdx,
  output logic [ZCW-1:0]    zeroCnt,
  output logic [ZD*P-1:0]   zeroElem,
  output logic [P-1:0]      zeroSum
);
  strobe_t       stb;
  logic [IW-1:0] nodeIdx;

  msort_ctrl #(.DC(DC), .IW(IW)) uCtrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inLast(inLast),
    .inReady(inReady), .stb(stb), .nodeIdx(nodeIdx),
    .done(done), .finalSel(finalSel)
  );

  msort_dpath #(.P(P), .W(W), .K(K), .ZD(ZD), .IW(IW)) uDpath (
    .clk(clk), .rst(rst), .stb(stb), .nodeIdx(nodeIdx),
    .inElem(inElem), .inLlr(inLlr), .readSel(finalSel),
    .outCnt(outCnt), .outElem(outElem), .outLlr(outLlr), .outIdx(outIdx),
    .zeroCnt(zeroCnt), .zeroElem(zeroElem), .zeroSum(zeroSum)
  );
endmodule

// File: tb/nbldpc_msg_sorter_test.sv
`timescale 1ns/1ps
module nbldpc_msg_sorter_test;
  localparam int P = 4, DC = 4, K = 3, W = 4, ZD = 5;
  localparam int IW = 2, CW = 2, ZCW = 3;

  logic clk = 0, rst = 1;
  logic inValid = 0, inLast = 0;
  logic [P-1:0] inElem = '0;
  logic [W-1:0] inLlr = '0;
  logic inReady, done, finalSel;
  logic [CW-1:0] outCnt;
  logic [K*P-1:0] outElem;
  logic [K*W-1:0] outLlr;
  logic [K*IW-1:0] outIdx;
  logic [ZCW-1:0] zeroCnt;
  logic [ZD*P-1:0] zeroElem;
  logic [P-1:0] zeroSum;

  always #2 clk = ~clk;

  nbldpc_msg_sorter #(.P(P), .DC(DC), .K(K), .W(W), .ZD(ZD)) uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inElem(inElem), .inLlr(inLlr), .inLast(inLast), .done(done),
    .finalSel(finalSel), .outCnt(outCnt), .outElem(outElem), .outLlr(outLlr),
    .outIdx(outIdx), .zeroCnt(zeroCnt), .zeroElem(zeroElem), .zeroSum(zeroSum)
  );

  int checks = 0, errors = 0;
  bit finished = 0, armed = 0;

  // behavioural model
  int mL[$], mE[$], mI[$], zE[$];
  int mSum = 0, mNode = 0, mSel = 0;
  bit mStart = 1, expDone = 0, resValid = 1;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic void modelAccept(int e, int l, bit last);
    int pos;
    if (mStart) begin
      mL.delete(); mE.delete(); mI.delete(); zE.delete();
      mSum = 0; mStart = 0; resValid = 0;
    end
    if (l == 0) begin
      if (zE.size() < ZD) zE.push_back(e);
      mSum ^= e;
    end else begin
      pos = 0;
      foreach (mL[i]) if (mL[i] <= l) pos = i + 1;
      mL.insert(pos, l); mE.insert(pos, e); mI.insert(pos, mNode);
      if (mL.size() > K) begin
        void'(mL.pop_back()); void'(mE.pop_back()); void'(mI.pop_back());
      end
    end
    if (last) begin
      if (mNode == DC - 1) begin
        mNode = 0; expDone = 1; mStart = 1; resValid = 1; mSel = (DC - 1) % 2;
      end else mNode++;
    end
  endfunction

  task automatic sendMsg(int e, int l, bit last);
    @(negedge clk);
    inValid = 1; inElem = P'(e); inLlr = W'(l); inLast = last;
    if (!inReady) @(negedge clk);
    @(posedge clk);
    #1 modelAccept(e, l, last);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    inValid = 0; inLast = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic compareResults(string ctx);
    chk(outCnt == CW'(mL.size()), {"R5 count ", ctx}, outCnt, mL.size());
    for (int i = 0; i < mL.size() && i < K; i++) begin
      chk(outLlr[i*W +: W] == W'(mL[i]), {"R5 llr ", ctx}, outLlr[i*W +: W], mL[i]);
      chk(outElem[i*P +: P] == P'(mE[i]), {"R6 elem order ", ctx}, outElem[i*P +: P], mE[i]);
      chk(outIdx[i*IW +: IW] == IW'(mI[i]), {"R7 node tag ", ctx}, outIdx[i*IW +: IW], mI[i]);
    end
    chk(zeroCnt == ZCW'(zE.size()), {"R2 zero count ", ctx}, zeroCnt, zE.size());
    for (int i = 0; i < zE.size(); i++)
      chk(zeroElem[i*P +: P] == P'(zE[i]), {"R2 zero elem ", ctx}, zeroElem[i*P +: P], zE[i]);
    chk(zeroSum == P'(mSum), {"R3 xor sum ", ctx}, zeroSum, mSum);
    chk(finalSel == 1'(mSel), {"R4 final buffer ", ctx}, finalSel, mSel);
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (armed && !rst) begin
      chk(done == expDone, "R8 done pulse", done, expDone);
      chk(inReady == !expDone, "R8 ready", inReady, !expDone);
      if (resValid) compareResults(expDone ? "at done" : "R9 held");
      expDone = 0;
    end
  end

  task automatic runUpdate(int mode);
    for (int n = 0; n < DC; n++) begin
      int m;
      m = (mode == 3) ? 2 : $urandom_range(1, 4);
      for (int j = 0; j < m; j++) begin
        int e, l;
        e = $urandom_range(0, 15);
        case (mode)
          0: l = ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(1, 15);
          1: l = 0;
          2: l = 5;
          default: l = ((n % 2) == 1 || j == 1) ? 0 : 3 + n;
        endcase
        sendMsg(e, l, j == m - 1);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(outCnt == 0, "R1 list count", outCnt, 0);
    chk(zeroCnt == 0, "R1 zero count", zeroCnt, 0);
    chk(zeroSum == 0, "R1 zero sum", zeroSum, 0);
    chk(done == 0, "R1 done", done, 0);
    chk(inReady == 1, "R1 ready", inReady, 1);
    chk(finalSel == 0, "R1 sel", finalSel, 0);
    armed = 1;

    for (int u = 0; u < 12; u++) begin
      runUpdate(0);
      idle(2);
    end
    runUpdate(1);  // all LLRs zero: zero store overflows
    idle(2);
    runUpdate(2);  // all LLRs equal: ties keep arrival order
    idle(1);
    runUpdate(3);  // odd nodes send only zero LLRs
    @(negedge clk);
    // R10: nodes 1 and 3 had no nonzero message; list keeps nodes 0 and 2
    chk(outCnt == 2, "R10 copy through empty rounds", outCnt, 2);
    chk(outIdx[IW +: IW] == 2, "R10 tag after copy", outIdx[IW +: IW], 2);
    idle(1);
    // back-to-back updates
    for (int u = 0; u < 4; u++) runUpdate(0);
    idle(3);

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule